// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Port

This block is the device-side serial interface of a 16-bit sigma-delta converter. It starts conversions in a modelled converter core and takes back a parallel result with a done strobe. Between conversions it rests in a low-power state. When chip-select is low it enters its data phase and shifts the result out, most significant bit first. The serial clock, chip-select and serial data input pins are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are detected on the synchronized levels.

The end of a read, and so the start of the next conversion, depends on the serial clock. The bench checks this through the number of falling edges and through the idle level latched at the moment the data phase begins. Raising chip-select while the clock is low cuts a read short and starts a conversion at once. With chip-select tied low (2-wire use) the data pin is high while a conversion runs. Four configuration bits arrive on the data input during a read and are held until the next conversion starts.

Top module: `sdAdcSerialPort`

## Requirements
- R1: After reset `sdoOe` is low while `csN` is high, all configuration outputs are 0, `sleepNow` is 0, and exactly one `convStart` pulse is issued without any pin activity.
- R2: With the serial clock low when the data phase begins, `sdo` presents result bit 15 at once. Each later falling edge of `sck` presents the next lower bit, down to bit 0.
- R3: With the serial clock low when the data phase begins, the 16th falling edge starts a conversion, and no earlier falling edge does.
- R4: With the serial clock high when the data phase begins, `sdo` reads 0 until the first falling edge. Falling edges 1 to 16 present bits 15 down to 0, and the 17th falling edge starts a conversion.
- R5: A rising `csN` during the data phase while `sck` is low discards the remaining bits and starts a conversion.
- R6: A rising `csN` during the data phase while `sck` is high starts no conversion. The next read starts again from bit 15.
- R7: Serial clock edges and chip-select changes during a conversion start nothing and do not disturb the next result.
- R8: While a conversion runs and `csN` is low, `sdo` is 1 and `sdoOe` is 1.
- R9: `sdoOe` is 0 once `csN` has been high for three system clocks.
- R10: The first four `sdi` values sampled on rising `sck` edges of a read are, in order, `cfgEnable[0]`, `cfgEnable[1]`, `cfgSlowRate` and `cfgSleep`. They reach these outputs in the cycle `convStart` is high, and never at another time.
- R11: A read that ends with fewer than four rising `sck` edges leaves the configuration outputs unchanged.
- R12: `sleepNow` is 1 in the rest state between conversion end and the data phase only when `cfgSleep` is 1. It is 0 while a conversion runs.
- R13: `convStart` is high for exactly one system clock per conversion start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip-select pin, active low, asynchronous |
| sck | input | 1 | Serial clock pin, asynchronous |
| sdi | input | 1 | Serial configuration data pin |
| sdo | output | 1 | Serial data out / busy flag |
| sdoOe | output | 1 | Output enable for `sdo` (tri-state control) |
| convStart | output | 1 | One-cycle conversion start to the core |
| convDone | input | 1 | Conversion complete strobe from the core |
| convResult | input | 16 | Conversion result, valid with `convDone` |
| cfgEnable | output | 2 | Active enable configuration bits |
| cfgSlowRate | output | 1 | Active rate select (1 = slower output rate) |
| cfgSleep | output | 1 | Active rest mode select (1 = sleep, 0 = nap) |
| sleepNow | output | 1 | High while resting in sleep mode |

## Verification
A pin change becomes visible to the state logic two clocks later, after the synchronizer. The state, shift register and `convStart` register update on the next edge. Every result that follows a pin change is therefore due by the third rising edge. The bench drives one pin change at a time. It then waits six falling clock edges before it samples `sdo`, `sdoOe`, the configuration outputs or its count of start pulses, and it makes the next change only after that sample. A `convDone` pulse needs one clock to move the block into rest, plus up to three more when chip-select is already low. The bench uses the same six-edge settle after each done pulse before it looks at the first data bit.

// File: rtl/sdAdcPortPkg.sv
package sdAdcPortPkg;

  // number of configuration fields carried on sdi per read
  localparam int CFG_BITS = 4;

  typedef enum logic [1:0] {
    PH_CONVERT = 2'd0,
    PH_REST    = 2'd1,
    PH_DATA    = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capResult;  // latch parallel result from core
    logic loadShift;  // copy result into shifter, clear cfg capture
    logic shiftOut;   // advance shifter by one bit
    logic sampleCfg;  // take sdi into config shadow
    logic applyCfg;   // conversion starting: commit shadow if complete
  } dpStrobe_t;

endpackage

// File: rtl/sdAdcPinSync.sv
module sdAdcPinSync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] level
);

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      meta  <= RST_VAL;
      level <= RST_VAL;
    end else begin
      meta  <= pinIn;
      level <= meta;
    end
  end

endmodule

// File: rtl/sdAdcPortCtrl.sv
module sdAdcPortCtrl
  import sdAdcPortPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csLvl,
  input  logic       sckLvl,
  input  logic       convDone,
  output phase_t     phase,
  output logic       markOn,
  output logic       convStart,
  output dpStrobe_t  st
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_LOW  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_HIGH = CNT_W'(DATA_W);

  logic             csPrev;
  logic             sckPrev;
  logic             idleHigh;
  logic             kick;
  logic [CNT_W-1:0] fallCnt;

  logic csRise, sckFall, sckRise, inData, finalFall, abortNow, startNow;

  always_comb begin
    csRise    = csLvl & ~csPrev;
    sckFall   = ~sckLvl & sckPrev;
    sckRise   = sckLvl & ~sckPrev;
    inData    = (phase == PH_DATA);
    finalFall = sckFall && (fallCnt == (idleHigh ? LAST_HIGH : LAST_LOW));
    abortNow  = inData && csRise && !sckLvl;
    startNow  = abortNow || (inData && !csRise && finalFall);
    markOn    = inData && idleHigh && (fallCnt == '0);

    st.capResult = (phase == PH_CONVERT) && convDone;
    st.loadShift = (phase == PH_REST) && !csLvl;
    st.shiftOut  = inData && !csRise && sckFall && !markOn;
    st.sampleCfg = inData && !csRise && sckRise;
    st.applyCfg  = startNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_CONVERT;
      kick      <= 1'b1;
      convStart <= 1'b0;
      csPrev    <= 1'b1;
      sckPrev   <= 1'b0;
      idleHigh  <= 1'b0;
      fallCnt   <= '0;
    end else begin
      csPrev    <= csLvl;
      sckPrev   <= sckLvl;
      kick      <= 1'b0;
      convStart <= kick | startNow;
      unique case (phase)
        PH_CONVERT: if (convDone) phase <= PH_REST;
        PH_REST: begin
          if (!csLvl) begin
            phase    <= PH_DATA;
            idleHigh <= sckLvl;
            fallCnt  <= '0;
          end
        end
        PH_DATA: begin
          if (csRise) begin
            phase <= sckLvl ? PH_REST : PH_CONVERT;
          end else if (sckFall) begin
            fallCnt <= fallCnt + 1'b1;
            if (finalFall) phase <= PH_CONVERT;
          end
        end
        default: phase <= PH_CONVERT;
      endcase
    end
  end

endmodule

// File: rtl/sdAdcPortData.sv
module sdAdcPortData
  import sdAdcPortPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           st,
  input  phase_t              phase,
  input  logic                markOn,
  input  logic                csLvl,
  input  logic                sdiLvl,
  input  logic [DATA_W-1:0]   convResult,
  output logic                sdo,
  output logic                sdoOe,
  output logic [CFG_BITS-1:0] cfgActive
);

  localparam int CNT_W = $clog2(CFG_BITS + 1);
  localparam int IDX_W = $clog2(CFG_BITS);
  localparam logic [CNT_W-1:0] CFG_FULL = CNT_W'(CFG_BITS);

  logic [DATA_W-1:0]   resReg;
  logic [DATA_W-1:0]   shReg;
  logic [CFG_BITS-1:0] cfgShadow;
  logic [CNT_W-1:0]    cfgCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resReg    <= '0;
      shReg     <= '0;
      cfgShadow <= '0;
      cfgCnt    <= '0;
      cfgActive <= '0;
    end else begin
      if (st.capResult) resReg <= convResult;

      if (st.loadShift) begin
        shReg  <= resReg;
        cfgCnt <= '0;
      end else if (st.shiftOut) begin
        shReg <= {shReg[DATA_W-2:0], 1'b0};
      end

      if (st.sampleCfg && (cfgCnt < CFG_FULL)) begin
        cfgShadow[cfgCnt[IDX_W-1:0]] <= sdiLvl;
        cfgCnt <= cfgCnt + 1'b1;
      end

      if (st.applyCfg && (cfgCnt == CFG_FULL)) cfgActive <= cfgShadow;
    end
  end

  always_comb begin
    sdoOe = ~csLvl;
    if (phase == PH_DATA) sdo = markOn ? 1'b0 : shReg[DATA_W-1];
    else                  sdo = 1'b1;
  end

endmodule

// File: rtl/sdAdcSerialPort.sv
module sdAdcSerialPort
  import sdAdcPortPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  output logic              convStart,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult,
  output logic [1:0]        cfgEnable,
  output logic              cfgSlowRate,
  output logic              cfgSleep,
  output logic              sleepNow
);

  logic [2:0]          pinLvl;
  phase_t              phase;
  logic                markOn;
  dpStrobe_t           st;
  logic [CFG_BITS-1:0] cfgActive;

  sdAdcPinSync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .pinIn ({csN, sck, sdi}),
    .level (pinLvl)
  );

  sdAdcPortCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csLvl     (pinLvl[2]),
    .sckLvl    (pinLvl[1]),
    .convDone  (convDone),
    .phase     (phase),
    .markOn    (markOn),
    .convStart (convStart),
    .st        (st)
  );

  sdAdcPortData #(.DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .phase      (phase),
    .markOn     (markOn),
    .csLvl      (pinLvl[2]),
    .sdiLvl     (pinLvl[0]),
    .convResult (convResult),
    .sdo        (sdo),
    .sdoOe      (sdoOe),
    .cfgActive  (cfgActive)
  );

  assign cfgEnable   = cfgActive[1:0];
  assign cfgSlowRate = cfgActive[2];
  assign cfgSleep    = cfgActive[3];
  assign sleepNow    = (phase == PH_REST) && cfgActive[3];

endmodule

// File: rtl/sdAdcPortChecker.sv
module sdAdcPortChecker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sdo,
  input logic       sdoOe,
  input logic       convStart,
  input logic [3:0] cfgBus,
  input logic       sleepNow
);

  logic [1:0] csHighRun;

  always_ff @(posedge clk) begin
    if (!rstN)            csHighRun <= '0;
    else if (!csN)        csHighRun <= '0;
    else if (csHighRun != 2'd3) csHighRun <= csHighRun + 1'b1;
  end

  // R9
  sdo_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csHighRun == 2'd3) |-> !sdoOe);

  // R13
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R10
  cfg_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgBus) |-> convStart);

  // R8
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && sdoOe) |-> sdo);

  // R12
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !sleepNow);

endmodule

bind sdAdcSerialPort sdAdcPortChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .sdo       (sdo),
  .sdoOe     (sdoOe),
  .convStart (convStart),
  .cfgBus    ({cfgSleep, cfgSlowRate, cfgEnable}),
  .sleepNow  (sleepNow)
);

// File: tb/sdAdcSerialPort_bench.sv
module sdAdcSerialPort_bench;

  localparam int CONV_CYCLES = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdoOe, convStart, convDone;
  logic [15:0] convResult;
  logic [1:0]  cfgEnable;
  logic        cfgSlowRate, cfgSleep, sleepNow;

  int          checks = 0;
  int          fails = 0;
  int          startCount = 0;
  int          doneCount = 0;
  logic        prevStart = 1'b0;
  logic [15:0] nextResult = 16'hA5C3;
  logic [15:0] lastResult = 16'h0000;
  logic [3:0]  expCfg = 4'b0000;

  always #5 clk = ~clk;

  sdAdcSerialPort u_sdAdcSerialPort (
    .clk (clk), .rstN (rstN), .csN (csN), .sck (sck), .sdi (sdi),
    .sdo (sdo), .sdoOe (sdoOe), .convStart (convStart),
    .convDone (convDone), .convResult (convResult),
    .cfgEnable (cfgEnable), .cfgSlowRate (cfgSlowRate),
    .cfgSleep (cfgSleep), .sleepNow (sleepNow)
  );

  function automatic logic [3:0] cfgNow();
    return {cfgSleep, cfgSlowRate, cfgEnable};
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (ok !== 1'b1) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic waitDone();
    int d;
    d = doneCount;
    while (doneCount == d) @(negedge clk);
    settle();
  endtask

  // idle-low pulse: rise samples sdi, fall advances data
  task automatic pulseLow(input logic v);
    sdi = v; sck = 1'b1; settle();
    sck = 1'b0; settle();
  endtask

  task automatic readLow(input int k, input logic [15:0] r, input logic [3:0] c);
    int s0;
    s0 = startCount;
    for (int i = 0; i < k; i++) begin
      pulseLow(i < 4 ? c[i] : 1'b0);
      if (i < 15) begin
        check(sdo === r[14-i], "R2 bit", int'(sdo), int'(r[14-i]));
        check(startCount == s0, "R3 early start", startCount, s0);
      end
    end
  endtask

  // converter core model
  initial begin
    convDone = 1'b0;
    convResult = '0;
    forever begin
      @(negedge clk);
      if (rstN && convStart) begin
        repeat (CONV_CYCLES) @(negedge clk);
        convResult = nextResult;
        lastResult = nextResult;
        convDone = 1'b1;
        @(negedge clk);
        convDone = 1'b0;
        doneCount++;
      end
    end
  end

  // start pulse monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && convStart) begin
        startCount++;
        check(!prevStart, "R13 pulse width", 2, 1);
      end
      prevStart = rstN && convStart;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [3:0]  c;
    int          s0;
    int          k;
    void'($urandom(32'd20240607));

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sdoOe === 1'b0, "R1 oe", int'(sdoOe), 0);
    check(cfgNow() === 4'b0, "R1 cfg", int'(cfgNow()), 0);
    check(sleepNow === 1'b0, "R1 sleep", int'(sleepNow), 0);
    waitDone();
    check(startCount == 1, "R1 kickoff", startCount, 1);

    // directed: 4-wire idle-low full read with new configuration
    r = lastResult; nextResult = 16'h3C96;
    check(sleepNow === 1'b0, "R12 nap", int'(sleepNow), 0);
    csN = 1'b0; settle();
    check(sdoOe === 1'b1 && sdo === r[15], "R2 first bit", int'(sdo), int'(r[15]));
    s0 = startCount;
    c = 4'b1101;
    readLow(16, r, c);
    check(startCount == s0 + 1, "R3 16th fall", startCount, s0 + 1);
    expCfg = c;
    check(cfgNow() === expCfg, "R10 apply", int'(cfgNow()), int'(expCfg));
    csN = 1'b1; settle();
    check(sdoOe === 1'b0, "R9 release", int'(sdoOe), 0);
    check(sleepNow === 1'b0, "R12 converting", int'(sleepNow), 0);
    waitDone();
    check(sleepNow === 1'b1, "R12 sleep", int'(sleepNow), 1);

    // directed: abort after two bits (R5, R11)
    r = lastResult; nextResult = 16'h8001;
    csN = 1'b0; settle();
    check(sdo === r[15], "R5 sign", int'(sdo), int'(r[15]));
    s0 = startCount;
    pulseLow(1'b0);
    pulseLow(1'b1);
    check(sdo === r[13], "R5 bit", int'(sdo), int'(r[13]));
    csN = 1'b1; settle();
    check(startCount == s0 + 1, "R5 abort start", startCount, s0 + 1);
    check(cfgNow() === expCfg, "R11 keep cfg", int'(cfgNow()), int'(expCfg));

    // directed: chip-select rises with sck high (R6)
    waitDone();
    r = lastResult; nextResult = 16'h7FFE;
    csN = 1'b0; settle();
    s0 = startCount;
    sck = 1'b1; settle(); sck = 1'b0; settle();
    check(sdo === r[14], "R6 bit14", int'(sdo), int'(r[14]));
    sck = 1'b1; settle();
    csN = 1'b1; settle();
    check(startCount == s0, "R6 no start", startCount, s0);
    sck = 1'b0; settle();
    csN = 1'b0; settle();
    check(sdo === r[15], "R6 reread", int'(sdo), int'(r[15]));
    readLow(16, r, expCfg);
    check(startCount == s0 + 1, "R3 after reread", startCount, s0 + 1);

    // directed: pin activity during conversion (R7)
    s0 = startCount;
    pulseLow(1'b1); pulseLow(1'b0); pulseLow(1'b1);
    csN = 1'b1; settle();
    pulseLow(1'b1); pulseLow(1'b1);
    check(startCount == s0, "R7 ignored", startCount, s0);
    waitDone();
    r = lastResult; nextResult = 16'hF00D;
    csN = 1'b0; settle();
    check(sdo === r[15], "R7 result", int'(sdo), int'(r[15]));
    readLow(16, r, expCfg);
    check(startCount == s0 + 1, "R7 read end", startCount, s0 + 1);

    // directed: 2-wire, clock idles high (R4, R8)
    sck = 1'b1; settle();
    check(sdo === 1'b1 && sdoOe === 1'b1, "R8 busy", int'(sdo), 1);
    waitDone();
    r = lastResult; nextResult = 16'h0FF0;
    check(sdo === 1'b0, "R4 ready marker", int'(sdo), 0);
    s0 = startCount;
    c = 4'b0100;
    for (int j = 1; j <= 17; j++) begin
      sdi = (j <= 4) ? c[j-1] : 1'b0;
      sck = 1'b0; settle();
      if (j <= 16) begin
        check(sdo === r[16-j], "R4 bit", int'(sdo), int'(r[16-j]));
        check(startCount == s0, "R4 early start", startCount, s0);
      end else begin
        check(startCount == s0 + 1, "R4 17th fall", startCount, s0 + 1);
        check(sdo === 1'b1, "R8 busy after", int'(sdo), 1);
      end
      sck = 1'b1; settle();
    end
    expCfg = c;
    check(cfgNow() === expCfg, "R10 apply 2-wire", int'(cfgNow()), int'(expCfg));

    // directed: 2-wire, clock idles low (R2, R3)
    sck = 1'b0; settle();
    waitDone();
    r = lastResult; nextResult = 16'h5555;
    check(sdo === r[15], "R2 2-wire first", int'(sdo), int'(r[15]));
    s0 = startCount;
    readLow(16, r, expCfg);
    check(startCount == s0 + 1, "R3 2-wire end", startCount, s0 + 1);
    csN = 1'b1; settle();

    // random 4-wire reads with random abort point
    for (int t = 0; t < 20; t++) begin
      waitDone();
      r = lastResult;
      nextResult = 16'($urandom);
      k = int'($urandom_range(16, 1));
      c = 4'($urandom);
      csN = 1'b0; settle();
      check(sdo === r[15], "R2 random first", int'(sdo), int'(r[15]));
      s0 = startCount;
      readLow(k, r, c);
      csN = 1'b1; settle();
      if (k == 16) check(startCount == s0 + 1, "R3 random end", startCount, s0 + 1);
      else         check(startCount == s0 + 1, "R5 random abort", startCount, s0 + 1);
      if (k >= 4) begin
        expCfg = c;
        check(cfgNow() === expCfg, "R10 random cfg", int'(cfgNow()), int'(expCfg));
      end else begin
        check(cfgNow() === expCfg, "R11 random keep", int'(cfgNow()), int'(expCfg));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule